// File: doc/BRIEF.md
# OTG Event Status and Interrupt Register

This block holds the sticky event flags for a dual-role USB controller and drives a level interrupt from them. Three line inputs come in asynchronously: the connector ID level, VBUS valid and B-session valid. Each passes through a two-flop synchronizer before its edges are detected. Role-change and protocol outcomes arrive as single-cycle pulses from logic outside the block. A one-cycle `wr_en` strobe with `wr_data` clears any flag whose data bit is 1. `rd_data` always shows the current register image.

Each flag can be recorded only while its bit in the `evt_en` input is 1. A-role flags can set only while the synchronized ID level is 0. B-role flags can set only while it is 1. Two read-only status bits sample the B-session level and the host negotiation result. They sample only when their associated event is recorded, so software reads the value that belongs to the event.

Top module: `otg_event_reg`

## Requirements
- R1: While `rst_n` is low, and at reset release, `rd_data` is 0 and `irq` is 0.
- R2: `rd_data[31]` shows the ID input two clock edges after it changes: 0 means A role and 1 means B role.
- R3: `irq` is 1 exactly when at least one flag in bits 27:16, 11:8 or 0 is 1. It falls only after a clearing write.
- R4: A write clears each flag whose `wr_data` bit is 1 and leaves flags whose bit is 0 unchanged. If a flag's set condition occurs in the same cycle as its clear, the flag stays set.
- R5: Bits 30:28, 15:12, 7:4 and 1 always read 0. Writes to them, and to bits 31, 3 and 2, change nothing.
- R6: A pulse on a pulse input sets its flag on the next edge when `evt_en` at that same bit is 1. If that enable is 0, the flag is not recorded. The pulse inputs map to bits as follows: host run 27, device run 26, hibernate 25, role-request confirm 23, role-request initiate 22, A idle 21, A B-host end 20, A host 19, A HNP 18, A SRP 17, B B-host end 11, B HNP 10, B session valid 9.
- R7: Flags 21:16 cannot set while bit 31 is 1. Flags 11:8 cannot set while bit 31 is 0.
- R8: Each transition of `id_pin` sets bit 24 exactly once, three edges after the change, in either role.
- R9: A falling `vbus_ok` sets bit 16, three edges later. Any edge of `bsess_ok` sets bit 8.
- R10: Bit 3 takes the synchronized B-session level only in the cycle that bit 8 is recorded. Otherwise it holds.
- R11: Bit 2 takes `hnp_ok` only in the cycle that flag 18 or flag 10 is recorded: 1 means success and 0 means failure.
- R12: Line levels present at reset release create no event. Edges count only from the third clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_pin | input | 1 | Connector ID level, asynchronous |
| vbus_ok | input | 1 | VBUS valid level, asynchronous |
| bsess_ok | input | 1 | B-session valid level, asynchronous |
| hnp_ok | input | 1 | Host negotiation result, sampled with an HNP pulse |
| host_run_p | input | 1 | Host run/stop set pulse (bit 27) |
| dev_run_p | input | 1 | Device run/stop set pulse (bit 26) |
| hib_p | input | 1 | Hibernation entry pulse (bit 25) |
| rr_cfm_p | input | 1 | Host role request confirm pulse (bit 23) |
| rr_init_p | input | 1 | Host role request initiate pulse (bit 22) |
| a_idle_p | input | 1 | A idle pulse (bit 21) |
| a_bhend_p | input | 1 | A-side B-host end pulse (bit 20) |
| a_host_p | input | 1 | A host pulse (bit 19) |
| a_hnp_p | input | 1 | A HNP change pulse (bit 18) |
| a_srp_p | input | 1 | A SRP detect pulse (bit 17) |
| b_bhend_p | input | 1 | B-host end pulse (bit 11) |
| b_hnp_p | input | 1 | B HNP change pulse (bit 10) |
| b_sessv_p | input | 1 | B session valid pulse (bit 9) |
| evt_en | input | 32 | Per-bit event enables |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_data | input | 32 | Clear mask |
| rd_data | output | 32 | Register image |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the inputs:
- Pulse inputs are sampled once per clock.
- `hnp_ok` is stable at the edge where an HNP pulse is sampled.
- Software reaches the flags only through `wr_en`.

The bench drives every input just after a rising edge and holds it for a full cycle. Pulses appear sparsely and the line levels toggle rarely, so each synchronized edge settles before the next one. A reference model computed from the requirements tracks the synchronizer delay, the role gating and the enable masks. Directed sequences then force the corner cases: a set and a clear in the same cycle, events with their enable off, events in the wrong role, and lines already high at reset release.

// File: rtl/otg_event_reg.sv
module otg_event_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        id_pin,
  input  logic        vbus_ok,
  input  logic        bsess_ok,
  input  logic        hnp_ok,
  input  logic        host_run_p,
  input  logic        dev_run_p,
  input  logic        hib_p,
  input  logic        rr_cfm_p,
  input  logic        rr_init_p,
  input  logic        a_idle_p,
  input  logic        a_bhend_p,
  input  logic        a_host_p,
  input  logic        a_hnp_p,
  input  logic        a_srp_p,
  input  logic        b_bhend_p,
  input  logic        b_hnp_p,
  input  logic        b_sessv_p,
  input  logic [31:0] evt_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq
);

  localparam logic [31:0] EV_MASK = 32'h0FFF_0F01;
  localparam logic [31:0] A_MASK  = 32'h003F_0000;
  localparam logic [31:0] B_MASK  = 32'h0000_0F00;
  localparam int          WARM    = 3;

  // line index: 2 = id, 1 = vbus, 0 = b-session
  logic [2:0]  s1, s2, pv;
  logic [1:0]  warm;
  logic [31:0] ev, src, set_w, clr;
  logic        bsv_q, hnp_q;

  wire       armed  = (warm == 2'(WARM));
  wire [2:0] edg    = armed ? (s2 ^ pv) : 3'b000;
  wire       role_b = s2[2];

  always_comb begin
    src     = '0;
    src[27] = host_run_p;
    src[26] = dev_run_p;
    src[25] = hib_p;
    src[24] = edg[2];
    src[23] = rr_cfm_p;
    src[22] = rr_init_p;
    src[21] = a_idle_p;
    src[20] = a_bhend_p;
    src[19] = a_host_p;
    src[18] = a_hnp_p;
    src[17] = a_srp_p;
    src[16] = edg[1] & ~s2[1];
    src[11] = b_bhend_p;
    src[10] = b_hnp_p;
    src[9]  = b_sessv_p;
    src[8]  = edg[0];
    set_w   = src & evt_en & EV_MASK & ~(role_b ? A_MASK : B_MASK);
  end

  assign clr = wr_en ? (wr_data & EV_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      pv    <= '0;
      warm  <= '0;
      ev    <= '0;
      bsv_q <= 1'b0;
      hnp_q <= 1'b0;
    end else begin
      s1 <= {id_pin, vbus_ok, bsess_ok};
      s2 <= s1;
      pv <= s2;
      if (!armed) warm <= warm + 2'd1;
      ev <= (ev & ~clr) | set_w;
      if (set_w[8]) bsv_q <= s2[0];
      if (set_w[18] | set_w[10]) hnp_q <= hnp_ok;
    end
  end

  assign rd_data = {role_b, 3'b000, ev[27:16], 4'h0, ev[11:8], 4'h0,
                    bsv_q, hnp_q, 1'b0, ev[0]};
  assign irq = |ev;

  a_r3_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ev & $past(wr_data & EV_MASK & ~set_w)) == 32'h0));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != 32'h0) |=> ((ev & $past(set_w)) == $past(set_w)));

  a_r7_no_a_in_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] |=> ((rd_data[21:16] & ~$past(rd_data[21:16])) == 6'h0));

  a_r7_no_b_in_a: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |=> ((rd_data[11:8] & ~$past(rd_data[11:8])) == 4'h0));

  a_r10_bsv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_w[8] |=> $stable(rd_data[3]));

  a_r11_hnp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_w[18] | set_w[10]) |=> $stable(rd_data[2]));

endmodule

// File: tb/tb_otg_event_reg.sv
`timescale 1ns/1ps
module tb_otg_event_reg;
  localparam logic [31:0] EVM = 32'h0FFF_0F01;
  localparam logic [31:0] PM  = 32'h0EFE_0E00;
  localparam logic [31:0] AM  = 32'h003F_0000;
  localparam logic [31:0] BM  = 32'h0000_0F00;

  logic clk = 0, rst_n = 0;
  logic id_pin = 0, vbus_ok = 0, bsess_ok = 0, hnp_ok = 0;
  logic [31:0] tp = '0, evt_en = '1, wr_data = '0;
  logic wr_en = 0;
  logic [31:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;

  logic [2:0] ms1, ms2, mpv;
  int mwarm;
  logic [31:0] mev;
  logic mbsv, mhnp;

  always #5 clk = ~clk;

  otg_event_reg dut (
    .clk(clk), .rst_n(rst_n), .id_pin(id_pin), .vbus_ok(vbus_ok),
    .bsess_ok(bsess_ok), .hnp_ok(hnp_ok),
    .host_run_p(tp[27]), .dev_run_p(tp[26]), .hib_p(tp[25]),
    .rr_cfm_p(tp[23]), .rr_init_p(tp[22]), .a_idle_p(tp[21]),
    .a_bhend_p(tp[20]), .a_host_p(tp[19]), .a_hnp_p(tp[18]),
    .a_srp_p(tp[17]), .b_bhend_p(tp[11]), .b_hnp_p(tp[10]),
    .b_sessv_p(tp[9]), .evt_en(evt_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  function automatic logic [31:0] exp_rd();
    return {ms2[2], 3'b000, mev[27:16], 4'h0, mev[11:8], 4'h0,
            mbsv, mhnp, 1'b0, mev[0]};
  endfunction

  function automatic logic [31:0] exp_set();
    logic [2:0] e;
    logic [31:0] s;
    e = (mwarm >= 3) ? (ms2 ^ mpv) : 3'b000;
    s = tp & PM;
    s[24] = e[2];
    s[16] = e[1] & ~ms2[1];
    s[8]  = e[0];
    s = s & evt_en;
    return ms2[2] ? (s & ~AM) : (s & ~BM);
  endfunction

  task automatic model_reset();
    ms1 = 0; ms2 = 0; mpv = 0; mwarm = 0; mev = 0; mbsv = 0; mhnp = 0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic [31:0] s, c;
    @(posedge clk);
    s = exp_set();
    c = wr_en ? (wr_data & EVM) : 32'h0;
    mev = (mev & ~c) | s;
    if (s[8]) mbsv = ms2[0];
    if (s[18] | s[10]) mhnp = hnp_ok;
    mpv = ms2; ms2 = ms1; ms1 = {id_pin, vbus_ok, bsess_ok};
    if (mwarm < 3) mwarm++;
    #2;
    chk(rd_data, exp_rd(), "R6 register image");
    chk({31'h0, irq}, {31'h0, (mev & EVM) != 0}, "R3 irq level");
  endtask

  task automatic pulse(input logic [31:0] bits);
    tp = bits; cyc(); tp = '0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240313));
    model_reset();
    id_pin = 1; vbus_ok = 1; bsess_ok = 1;
    repeat (3) @(posedge clk);
    #2;
    chk(rd_data, 32'h0, "R1 reset image");
    chk({31'h0, irq}, 32'h0, "R1 reset irq");
    @(negedge clk); rst_n = 1;
    cyc(); cyc();
    chk({31'h0, rd_data[31]}, 32'h1, "R2 role B after two edges");
    repeat (4) cyc();
    chk(rd_data, 32'h8000_0000, "R12 no event from levels at release");

    hnp_ok = 1; pulse(32'h0000_0400);
    chk(rd_data & 32'h0000_0404, 32'h0000_0404, "R11 B HNP captures success");
    chk({31'h0, irq}, 32'h1, "R3 irq set");
    pulse(32'h0008_0000);
    chk({31'h0, rd_data[19]}, 32'h0, "R7 A event blocked in B role");
    evt_en = 32'hF7FF_FFFF; pulse(32'h0800_0000);
    chk({31'h0, rd_data[27]}, 32'h0, "R6 disabled event not recorded");
    evt_en = '1; pulse(32'h0800_0000);
    chk({31'h0, rd_data[27]}, 32'h1, "R6 enabled event recorded");
    wr(32'h0);
    chk(rd_data & 32'h0800_0400, 32'h0800_0400, "R4 write zero no effect");
    wr(32'h0800_0000);
    chk({31'h0, rd_data[27]}, 32'h0, "R4 write one clears");
    tp = 32'h0400_0000; wr(32'hFFFF_FFFF); tp = '0;
    chk(rd_data, 32'h8400_0004, "R4 set wins, R5 reserved and status kept");
    wr(32'hFFFF_FFFF);
    chk({31'h0, irq}, 32'h0, "R3 irq low after clear");

    bsess_ok = 0; cyc(); cyc();
    chk({31'h0, rd_data[8]}, 32'h0, "R9 not yet after two edges");
    cyc();
    chk(rd_data & 32'h0000_0108, 32'h0000_0100, "R9 R10 bsess fall captured");
    wr(32'hFFFF_FFFF);
    evt_en = 32'hFFFF_FEFF; bsess_ok = 1; repeat (4) cyc();
    chk(rd_data & 32'h0000_0108, 32'h0, "R10 status holds when disabled");
    evt_en = '1;

    id_pin = 0; repeat (3) cyc();
    chk(rd_data & 32'h8100_0000, 32'h0100_0000, "R8 id change once, role A");
    wr(32'h0100_0000); repeat (5) cyc();
    chk({31'h0, rd_data[24]}, 32'h0, "R8 no repeat event");
    vbus_ok = 0; repeat (3) cyc();
    chk({31'h0, rd_data[16]}, 32'h1, "R9 vbus fall in A role");
    hnp_ok = 0; pulse(32'h0004_0000);
    chk(rd_data & 32'h0004_0004, 32'h0004_0000, "R11 A HNP captures failure");
    pulse(32'h0000_0800);
    chk({31'h0, rd_data[11]}, 32'h0, "R7 B event blocked in A role");
    wr(32'hFFFF_FFFF);

    for (int i = 0; i < 4000; i++) begin
      tp = $urandom & $urandom & $urandom & PM;
      hnp_ok = 1'($urandom);
      if ($urandom_range(0, 39) == 0) id_pin = ~id_pin;
      if ($urandom_range(0, 29) == 0) vbus_ok = ~vbus_ok;
      if ($urandom_range(0, 29) == 0) bsess_ok = ~bsess_ok;
      if ($urandom_range(0, 49) == 0)
        evt_en = ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom;
      wr_en = ($urandom_range(0, 5) == 0);
      wr_data = $urandom;
      cyc();
    end
    tp = '0; wr_en = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule